// File: doc/BRIEF.md
# Programmable Serial Clock Divider

This block derives the serial clock of an SPI flash host from the faster peripheral clock, nominally 80 MHz. It is set up by one packed 32-bit configuration word. Bit 31 selects pass-through, in which the serial clock is the peripheral clock itself. When bit 31 is clear, two six-bit fields set an integer divide. The field at bits 17:12 is the last value of a period counter, N = D-1. The field at bits 11:6 is the last counter value of the low phase, H, which software normally writes as D/2-1. The field at bits 5:0 is written by software as well, but the block does not read it.

The counter steps from 0 up to N and then returns to 0. The serial clock is low while the counter is at or below H and high above it. An odd divide factor therefore gives one more high cycle than low cycles.

A word is captured on a load strobe and held as pending. It is applied only when the running period ends, so a reconfiguration never cuts a phase short. The block also produces single-cycle rise and fall strobes in the peripheral clock domain, for use as clock enables by shift logic. While the enable is low, the serial clock rests at 0 and the counter rests at 0.

Top module: `sclk_divider`

## Requirements
- R1: After reset, sclk_o, rise_o and fall_o are 0, and the active setting is the reset word, a divide by 4 (N=3, H=1): 2 low and 2 high cycles.
- R2: While the active word has bit 31 set and the block is enabled, sclk_o follows the peripheral clock, both rise_o and fall_o are held at 1, and bits 17:0 have no effect. After a divide word is loaded, the divided output resumes.
- R3: In divide mode the counter cycles 0..N (N from bits 17:12), so the period is N+1 cycles, for any N from 1 to 63.
- R4: sclk_o is low for H+1 cycles and high for N-H cycles (H from bits 11:6), so an odd factor such as 5 gives 2 low and 3 high cycles.
- R5: Bits 5:0 of the word have no effect on the output.
- R6: A loaded word takes effect only at the end of the running period: the period in progress completes with its old high length.
- R7: rise_o is 1 for exactly the first cycle in which sclk_o is 1, and fall_o is 1 for exactly the first cycle in which sclk_o is 0 (divide mode).
- R8: One cycle after en_i falls, sclk_o is 0 and the counter is at 0, and no edge strobes follow. After en_i rises again, the counter starts from 0: with N=3 and H=1, sclk_o rises on the second clock edge.
- R9: cfg_word_i is sampled only in a cycle with cfg_load_i high. Changes of cfg_word_i without the strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Run enable; low parks the serial clock at 0 |
| cfg_load_i | input | 1 | Strobe that captures cfg_word_i as the pending setting |
| cfg_word_i | input | 32 | Packed word: bit 31 pass-through, 17:12 period count, 11:6 low-phase count, 5:0 unused |
| sclk_o | output | 1 | Serial clock |
| rise_o | output | 1 | Strobe marking the first high cycle of sclk_o |
| fall_o | output | 1 | Strobe marking the first low cycle of sclk_o |

## Verification
A counter that skips or overshoots its limit shows at the ports within one serial period, as a high or low run of the wrong length. The scoreboard measures every such run against the configured fields. A setting applied mid-period shows at once, as a shortened high run in the reconfiguration scenario. A strobe out of step with the level is caught in the very cycle it occurs, because every cycle compares the strobes with the sampled transitions of sclk_o.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;
  localparam int unsigned CFG_W   = 32;
  localparam int unsigned FLD_W   = 6;
  localparam int unsigned BYP_BIT = 31;
  localparam int unsigned PER_LSB = 12;
  localparam int unsigned HI_LSB  = 6;

  typedef struct packed {
    logic             byp;
    logic [FLD_W-1:0] per;
    logic [FLD_W-1:0] hi;
  } clkcfg_t;

  function automatic clkcfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    clkcfg_t c;
    c.byp = w[BYP_BIT];
    c.per = w[PER_LSB +: FLD_W];
    c.hi  = w[HI_LSB +: FLD_W];
    return c;
  endfunction
endpackage

// File: rtl/sclkdiv_cfg.sv
module sclkdiv_cfg
  import sclkdiv_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_WORD = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CFG_W-1:0] word_i,
  input  logic             wrap_i,
  output clkcfg_t          act_o,
  output clkcfg_t          nxt_o
);
  localparam clkcfg_t RST_CFG = unpack_cfg(RST_WORD);

  clkcfg_t pend_q;
  clkcfg_t act_q, act_d;
  logic    pv_q, pv_d;
  logic    apply;
  logic    unused_bits;

  // bits 30:18 and the low field are never decoded
  assign unused_bits = ^{word_i[BYP_BIT-1:PER_LSB+FLD_W], word_i[HI_LSB-1:0]};

  always_comb begin
    apply = pv_q && (!en_i || wrap_i);
    act_d = apply ? pend_q : act_q;
    pv_d  = load_i || (pv_q && !apply);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= RST_CFG;
      act_q  <= RST_CFG;
      pv_q   <= 1'b0;
    end else begin
      if (load_i) pend_q <= unpack_cfg(word_i);
      act_q <= act_d;
      pv_q  <= pv_d;
    end
  end

  assign act_o = act_q;
  assign nxt_o = act_d;
endmodule

// File: rtl/sclkdiv_cnt.sv
module sclkdiv_cnt
  import sclkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  clkcfg_t          act_i,
  input  clkcfg_t          nxt_i,
  output logic [FLD_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             lvl_o,
  output logic             lvl_nxt_o
);
  logic [FLD_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;

  always_comb begin
    wrap_o = act_i.byp || (cnt_q == act_i.per);
    if (!en_i || nxt_i.byp || wrap_o) cnt_d = '0;
    else                              cnt_d = cnt_q + 1'b1;
    lvl_d = en_i && !nxt_i.byp && (cnt_d > nxt_i.hi);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign lvl_o     = lvl_q;
  assign lvl_nxt_o = lvl_d;
endmodule

// File: rtl/sclkdiv_out.sv
module sclkdiv_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic byp_i,
  input  logic lvl_i,
  input  logic lvl_nxt_i,
  output logic run_o,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  logic run_q, rise_q, fall_q;
  logic rise_d, fall_d;

  always_comb begin
    rise_d = lvl_nxt_i && !lvl_i;
    fall_d = !lvl_nxt_i && lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      run_q  <= en_i;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign run_o  = run_q;
  assign sclk_o = byp_i ? (clk_i & run_q) : lvl_i;
  assign rise_o = byp_i ? run_q : rise_q;
  assign fall_o = byp_i ? run_q : fall_q;
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
  import sclkdiv_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_WORD = 32'h0000_3043
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cfg_load_i,
  input  logic [CFG_W-1:0] cfg_word_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n;
  clkcfg_t          act, nxt;
  logic [FLD_W-1:0] cnt;
  logic             wrap, lvl, lvl_nxt, run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  sclkdiv_cfg #(.RST_WORD(RST_WORD)) u_cfg (
    .clk_i (clk_i), .rst_ni(rst_n), .en_i(en_i), .load_i(cfg_load_i),
    .word_i(cfg_word_i), .wrap_i(wrap), .act_o(act), .nxt_o(nxt)
  );

  sclkdiv_cnt u_cnt (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(en_i), .act_i(act), .nxt_i(nxt),
    .cnt_o(cnt), .wrap_o(wrap), .lvl_o(lvl), .lvl_nxt_o(lvl_nxt)
  );

  sclkdiv_out u_out (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(en_i), .byp_i(act.byp),
    .lvl_i(lvl), .lvl_nxt_i(lvl_nxt), .run_o(run),
    .sclk_o(sclk_o), .rise_o(rise_o), .fall_o(fall_o)
  );
endmodule

// File: rtl/sclkdiv_chk.sv
module sclkdiv_chk
  import sclkdiv_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             byp_i,
  input logic [FLD_W-1:0] per_i,
  input logic [FLD_W-1:0] hi_i,
  input logic [FLD_W-1:0] cnt_i,
  input logic             lvl_i,
  input logic             run_i,
  input logic             rise_i,
  input logic             fall_i
);
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byp_i |-> cnt_i <= per_i);

  p_low_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_i && cnt_i <= hi_i) |-> !lvl_i);

  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !byp_i && cnt_i != per_i) |=> $stable({byp_i, per_i, hi_i}));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_i == '0 && !lvl_i));

  p_pulse_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byp_i |-> !(rise_i && fall_i));

  p_rise_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_i && rise_i) |-> lvl_i);

  p_fall_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_i && fall_i) |-> !lvl_i);

  p_byp_strobes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byp_i && run_i) |-> (rise_i && fall_i));
endmodule

bind sclk_divider sclkdiv_chk i_sclkdiv_chk (
  .clk_i (clk_i), .rst_ni(rst_n), .en_i(en_i),
  .byp_i (act.byp), .per_i(act.per), .hi_i(act.hi),
  .cnt_i (cnt), .lvl_i(lvl), .run_i(run),
  .rise_i(rise_o), .fall_i(fall_o)
);

// File: tb/test_sclk_divider.sv
module test_sclk_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        sclk, rise, fall;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  typedef struct { int hi; int lo; string req; } exp_t;
  exp_t sb[$];

  bit mon_on = 0, edge_chk = 0, armed = 0, prev = 0;
  int run_len = 0, hi_meas = 0;

  always #5 clk = ~clk;

  sclk_divider i_sclk_divider (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cfg_load_i(cfg_load),
    .cfg_word_i(cfg_word), .sclk_o(sclk), .rise_o(rise), .fall_o(fall)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit byp, int per, int hi, int low);
    return {byp, 13'b0, 6'(per), 6'(hi), 6'(low)};
  endfunction

  function automatic logic [31:0] divw(int d);
    return mk(0, d - 1, d / 2 - 1, d - 1);
  endfunction

  // monitor: measures complete high/low runs and checks strobes
  always @(negedge clk) begin
    bit lvl;
    exp_t e;
    lvl = sclk;
    if (edge_chk) begin
      chk(rise === (lvl && !prev), "R7", "rise_o", int'(rise), int'(lvl && !prev));
      chk(fall === (!lvl && prev), "R7", "fall_o", int'(fall), int'(!lvl && prev));
    end
    if (!mon_on) armed = 0;
    else if (!armed) begin
      if (lvl && !prev) begin armed = 1; run_len = 1; end
    end else if (lvl == prev) run_len++;
    else if (!lvl) begin hi_meas = run_len; run_len = 1; end
    else begin
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(hi_meas == e.hi, e.req, "high run", hi_meas, e.hi);
        chk(run_len == e.lo, e.req, "low run", run_len, e.lo);
      end
      run_len = 1;
    end
    prev = lvl;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [31:0] w);
    @(negedge clk);
    cfg_load = 1'b1; cfg_word = w;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic arm_mon();
    @(negedge clk);
    while (sclk) @(negedge clk);
    mon_on = 1;
  endtask

  task automatic drain(string req);
    for (int t = 0; t < 2000 && sb.size() > 0; t++) @(negedge clk);
    if (sb.size() > 0) begin
      chk(0, req, "scoreboard left", sb.size(), 0);
      sb.delete();
    end
    mon_on = 0;
  endtask

  task automatic run_sb(int hi, int lo, int k, string req);
    for (int i = 0; i < k; i++) sb.push_back('{hi, lo, req});
    arm_mon();
    drain(req);
  endtask

  initial begin
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      chk(sclk == 0 && rise == 0 && fall == 0, "R1", "outputs in reset", int'({sclk, rise, fall}), 0);
    end
    rst_n = 1'b1;
    settle(4);
    chk(sclk == 0 && rise == 0 && fall == 0, "R1", "outputs after reset", int'({sclk, rise, fall}), 0);
    edge_chk = 1;
    en = 1'b1;
    settle(10);
    run_sb(2, 2, 3, "R1");

    // R4 odd factor, R3 range
    load(divw(5)); settle(30);  run_sb(3, 2, 4, "R4");
    load(divw(2)); settle(20);  run_sb(1, 1, 4, "R3");
    load(divw(64)); settle(140); run_sb(32, 32, 2, "R3");
    load(mk(0, 9, 6, 9)); settle(140); run_sb(3, 7, 3, "R4");

    // R5 low field ignored
    load(mk(0, 5, 2, 0));  settle(30); run_sb(3, 3, 3, "R5");
    load(mk(0, 5, 2, 63)); settle(30); run_sb(3, 3, 3, "R5");

    // R9 word without strobe ignored
    load(divw(4)); settle(30);
    @(negedge clk); cfg_word = divw(10);
    settle(40);
    run_sb(2, 2, 3, "R9");

    // R6 change mid-period completes old period
    load(divw(8)); settle(40);
    sb.push_back('{4, 2, "R6"});
    sb.push_back('{2, 2, "R6"});
    sb.push_back('{2, 2, "R6"});
    arm_mon();
    do @(negedge clk); while (!rise);
    cfg_load = 1'b1; cfg_word = divw(4);
    @(negedge clk);
    cfg_load = 1'b0;
    drain("R6");

    // R8 disable and restart
    settle(20);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk(sclk == 0, "R8", "sclk one cycle after disable", int'(sclk), 0);
    repeat (15) begin
      @(negedge clk);
      chk(sclk == 0 && rise == 0 && fall == 0, "R8", "idle outputs", int'({sclk, rise, fall}), 0);
    end
    en = 1'b1;
    @(negedge clk);
    chk(sclk == 0, "R8", "first edge after enable", int'(sclk), 0);
    @(negedge clk);
    chk(sclk == 1 && rise == 1, "R8", "second edge after enable", int'({sclk, rise}), 3);

    // R2 pass-through with junk divide fields
    settle(10);
    edge_chk = 0;
    load(mk(1, 5, 2, 7));
    settle(10);
    repeat (6) begin
      @(posedge clk); #2;
      chk(sclk == 1, "R2", "sclk in high half", int'(sclk), 1);
      @(negedge clk); #2;
      chk(sclk == 0, "R2", "sclk in low half", int'(sclk), 0);
      chk(rise == 1 && fall == 1, "R2", "strobes held", int'({rise, fall}), 3);
    end
    @(negedge clk); en = 1'b0;
    settle(2);
    @(posedge clk); #2;
    chk(sclk == 0 && rise == 0, "R8", "pass-through disabled", int'({sclk, rise}), 0);
    @(negedge clk); en = 1'b1;
    load(divw(4));
    settle(10);
    edge_chk = 1;
    run_sb(2, 2, 3, "R2");

    settle(5);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule